// File: doc/BRIEF.md
# Reduced-Precision Fractional Multiplier

This block multiplies two 24-bit two's-complement fractional numbers (format 1.23, range -1.0 to just under +1.0) the way a low-cost audio signal processor does it: at reduced internal precision. Each operand is cut down to its upper 16 bits by dropping the low bits, with no rounding. The two narrowed operands form a signed 16x16 product. The sign-extension bit at the top of that product is discarded, which leaves a 31-bit fractional result. The upper 24 bits of that result are presented as the output.

Because nothing guards against overflow, the block reproduces the quantization artefacts of such a machine exactly. Squaring -1.0 gives -1.0, and products of near-full-scale values lose their lowest bits. The block accepts one operand pair per cycle, marked by a valid strobe. The result appears on a registered output with its own valid strobe one cycle later. It is meant to sit in a datapath that models or replaces such a processor bit for bit. Accumulation, saturation and rounding choices belong to the surrounding logic.

Top module: `redprec_fmul`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `res_valid` and `res_data` become 0 at that edge.
- R2: Bits [7:0] of `op_a` and `op_b` have no effect on `res_data`; only bits [23:8] of each operand take part.
- R3: `res_data` equals bits [30:7] of the 32-bit signed product of `op_a[23:8]` and `op_b[23:8]`, with bit 31 dropped and no rounding. A zero upper operand field therefore yields 0.
- R4: 0x7FFFFF times 0x7FFFFF gives 0x7FFE00, and 0x7FFFFF times 0x400000 gives 0x3FFF80.
- R5: 0x800000 times 0x800000 (-1.0 squared) gives 0x800000. The result wraps and is not saturated.
- R6: 0x800000 times 0x7FFFFF gives 0x800100.
- R7: A pair presented with `op_valid` high at a rising edge appears on `res_data` after that edge. `res_valid` at each edge takes the value `op_valid` had at that edge.
- R8: When `op_valid` is low at an edge, `res_data` keeps its previous value.
- R9: Small operands lose precision: 0x0020C5 times 0x0020C5 gives 0x000008.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operand pair strobe |
| op_a | input | 24 | First fractional operand, two's complement 1.23 |
| op_b | input | 24 | Second fractional operand, two's complement 1.23 |
| res_valid | output | 1 | Result strobe, one cycle after `op_valid` |
| res_data | output | 24 | Truncated fractional product, two's complement 1.23 |

## Verification
Two of the block's functions can fall in the same cycle: a new pair is accepted while the previous pair's result is being presented. The bench provokes this with back-to-back strobes whose pairs differ only in their low byte, or differ completely. It judges each cycle's output against its own pair alone, so a result that leaks from one pair into the next is caught. The wrap of -1.0 squared is also run in such a back-to-back stream. This shows that the overflow case neither stalls nor corrupts the neighbouring results.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

    // Operand and result formats
    localparam int unsigned FMUL_OPW   = 24;  // full operand width
    localparam int unsigned FMUL_KEEPW = 16;  // bits retained per operand
    localparam int unsigned FMUL_OUTW  = 24;  // result width

    // Derived widths
    localparam int unsigned FMUL_PRODW = 2 * FMUL_KEEPW;   // raw signed product
    localparam int unsigned FMUL_FRACW = FMUL_PRODW - 1;   // product without duplicate sign
    localparam int unsigned FMUL_DROPW = FMUL_FRACW - FMUL_OUTW;

    typedef logic signed [FMUL_KEEPW-1:0] fmul_narrow_t;
    typedef logic signed [FMUL_PRODW-1:0] fmul_prod_t;
    typedef logic        [FMUL_OUTW-1:0]  fmul_word_t;

    // Narrowed operand pair travelling to the multiplier
    typedef struct packed {
        fmul_narrow_t lhs;
        fmul_narrow_t rhs;
    } fmul_pair_t;

    // Registered result
    typedef struct packed {
        logic       valid;
        fmul_word_t data;
    } fmul_res_t;

    // Keep the upper KEEPW bits of a full-width operand (plain bit dropping)
    function automatic fmul_narrow_t fmul_narrow(input logic [FMUL_OPW-1:0] v);
        return fmul_narrow_t'(v[FMUL_OPW-1 -: FMUL_KEEPW]);
    endfunction

endpackage

// File: rtl/fmul_narrow.sv
module fmul_narrow
    import fmul_pkg::*;
#(
    parameter int unsigned NOPS = 2
) (
    input  logic [NOPS-1:0][FMUL_OPW-1:0] wide_in,
    output fmul_narrow_t [NOPS-1:0]       narrow_out
);

    generate
        for (genvar i = 0; i < NOPS; i++) begin : g_op
            always_comb narrow_out[i] = fmul_narrow(wide_in[i]);
        end
    endgenerate

endmodule

// File: rtl/fmul_core.sv
module fmul_core
    import fmul_pkg::*;
(
    input  fmul_pair_t pair,
    output fmul_prod_t prod
);

    always_comb prod = fmul_prod_t'(pair.lhs) * fmul_prod_t'(pair.rhs);

endmodule

// File: rtl/fmul_align.sv
module fmul_align
    import fmul_pkg::*;
(
    input  fmul_prod_t prod,
    output fmul_word_t word
);

    // Bit FMUL_PRODW-1 duplicates the sign and is discarded; the top OUTW
    // bits of the remaining fraction form the result, low bits are dropped.
    logic [FMUL_FRACW-1:0] frac;

    always_comb begin
        frac = prod[FMUL_FRACW-1:0];
        word = frac[FMUL_FRACW-1 -: FMUL_OUTW];
    end

endmodule

// File: rtl/redprec_fmul.sv
module redprec_fmul
    import fmul_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic [FMUL_OPW-1:0] op_a,
    input  logic [FMUL_OPW-1:0] op_b,
    output logic                res_valid,
    output logic [FMUL_OUTW-1:0] res_data
);

    localparam int unsigned NOPS = 2;

    logic [NOPS-1:0][FMUL_OPW-1:0] wide;
    fmul_narrow_t [NOPS-1:0]       narrow;
    fmul_pair_t                    pair;
    fmul_prod_t                    prod;
    fmul_word_t                    word;
    fmul_res_t                     res_q;

    always_comb begin
        wide[0]  = op_a;
        wide[1]  = op_b;
        pair.lhs = narrow[0];
        pair.rhs = narrow[1];
    end

    fmul_narrow #(.NOPS(NOPS)) u_narrow (
        .wide_in    (wide),
        .narrow_out (narrow)
    );

    fmul_core u_core (
        .pair (pair),
        .prod (prod)
    );

    fmul_align u_align (
        .prod (prod),
        .word (word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.valid <= op_valid;
            if (op_valid) res_q.data <= word;
        end
    end

    assign res_valid = res_q.valid;
    assign res_data  = res_q.data;

    // ---------------- assertions ----------------
    localparam logic [FMUL_OPW-1:0]  NEG_ONE_IN  = {1'b1, {(FMUL_OPW-1){1'b0}}};
    localparam logic [FMUL_OUTW-1:0] NEG_ONE_OUT = {1'b1, {(FMUL_OUTW-1){1'b0}}};

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (res_valid == 1'b0 && res_data == '0));

    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);

    assert_idle_follows_R7: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !res_valid);

    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(res_data));

    assert_low_bits_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (op_valid && $past(op_valid) && !$past(rst) &&
         op_a[FMUL_OPW-1 -: FMUL_KEEPW] == $past(op_a[FMUL_OPW-1 -: FMUL_KEEPW]) &&
         op_b[FMUL_OPW-1 -: FMUL_KEEPW] == $past(op_b[FMUL_OPW-1 -: FMUL_KEEPW]))
        |=> $stable(res_data));

    assert_zero_operand_R3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_a[FMUL_OPW-1 -: FMUL_KEEPW] == '0) |=> res_data == '0);

    assert_wrap_neg_one_R5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_a == NEG_ONE_IN && op_b == NEG_ONE_IN) |=> res_data == NEG_ONE_OUT);

endmodule

// File: tb/redprec_fmul_tb.sv
module redprec_fmul_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [23:0] op_a;
    logic [23:0] op_b;
    logic        res_valid;
    logic [23:0] res_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    redprec_fmul u_dut (
        .clk       (clk),
        .rst       (rst),
        .op_valid  (op_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .res_valid (res_valid),
        .res_data  (res_data)
    );

    // Expected value straight from R3
    function automatic logic [23:0] expect_prod(input logic [23:0] a, input logic [23:0] b);
        logic signed [31:0] p;
        p = $signed({{16{a[23]}}, a[23:8]}) * $signed({{16{b[23]}}, b[23:8]});
        return p[30:7];
    endfunction

    task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %06h expected %06h", req, got, exp);
        end
    endtask

    // Present one pair, return to idle, check at the following negedge
    task automatic one_pair(input string req, input logic [23:0] a, input logic [23:0] b,
                            input logic [23:0] exp);
        @(negedge clk);
        op_valid = 1'b1; op_a = a; op_b = b;
        @(negedge clk);
        op_valid = 1'b0; op_a = '0; op_b = '0;
        check({req, " valid"}, {23'd0, res_valid}, 24'd1);
        check(req, res_data, exp);
    endtask

    task automatic t_reset();
        rst = 1'b1; op_valid = 1'b0; op_a = '0; op_b = '0;
        repeat (3) @(negedge clk);
        check("R1 valid", {23'd0, res_valid}, 24'd0);
        check("R1 data", res_data, 24'd0);
        rst = 1'b0;
    endtask

    task automatic t_table();
        one_pair("R4 full*full", 24'h7FFFFF, 24'h7FFFFF, 24'h7FFE00);
        one_pair("R4 full*half", 24'h7FFFFF, 24'h400000, 24'h3FFF80);
        one_pair("R9 small", 24'h0020C5, 24'h0020C5, 24'h000008);
        one_pair("R6 neg*pos", 24'h800000, 24'h7FFFFF, 24'h800100);
        one_pair("R5 wrap", 24'h800000, 24'h800000, 24'h800000);
    endtask

    task automatic t_general();
        logic [23:0] av [6] = '{24'h123456, 24'hFEDCBA, 24'hC00000, 24'h000100, 24'hFFFFFF, 24'h5A5AA5};
        logic [23:0] bv [6] = '{24'h654321, 24'h0ABCDE, 24'hC00000, 24'h7FFF00, 24'h800000, 24'hA5A55A};
        for (int i = 0; i < 6; i++)
            one_pair("R3 general", av[i], bv[i], expect_prod(av[i], bv[i]));
        one_pair("R3 zero", 24'h0000FF, 24'h7FFFFF, 24'h000000);
    endtask

    task automatic t_low_bits();
        // same upper fields, different low bytes: same result as low bytes zero
        one_pair("R2 lowbyte", 24'h3456FF, 24'hABCD7F, expect_prod(24'h345600, 24'hABCD00));
        one_pair("R2 lowbyte neg", 24'h8000FF, 24'h8000FF, 24'h800000);
    endtask

    task automatic t_idle_hold();
        logic [23:0] prev;
        one_pair("R7 latch", 24'h200000, 24'h200000, 24'h080000);
        prev = res_data;
        // change operands with strobe low for several cycles
        for (int i = 0; i < 3; i++) begin
            op_a = 24'h7FFFFF - 24'(i); op_b = 24'h7FFFFF;
            @(negedge clk);
            check("R7 idle valid", {23'd0, res_valid}, 24'd0);
            check("R8 hold", res_data, prev);
        end
        op_a = '0; op_b = '0;
    endtask

    task automatic t_back_to_back();
        logic [23:0] av [5] = '{24'h7FFFFF, 24'h7FFF00, 24'h800000, 24'h0020C5, 24'hE00000};
        logic [23:0] bv [5] = '{24'h7FFFFF, 24'h7FFFAA, 24'h800000, 24'h0020C5, 24'h600000};
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            op_valid = 1'b1; op_a = av[i]; op_b = bv[i];
            @(negedge clk);
            check("R7 stream valid", {23'd0, res_valid}, 24'd1);
            check("R7 stream data", res_data, expect_prod(av[i], bv[i]));
        end
        op_valid = 1'b0; op_a = '0; op_b = '0;
        @(negedge clk);
        check("R7 stream end", {23'd0, res_valid}, 24'd0);
        check("R8 stream hold", res_data, expect_prod(av[4], bv[4]));
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        op_valid = 1'b1; op_a = 24'h7FFFFF; op_b = 24'h7FFFFF; rst = 1'b1;
        @(negedge clk);
        check("R1 mid valid", {23'd0, res_valid}, 24'd0);
        check("R1 mid data", res_data, 24'd0);
        rst = 1'b0; op_valid = 1'b0;
    endtask

    initial begin
        t_reset();
        t_table();
        t_general();
        t_low_bits();
        t_idle_hold();
        t_back_to_back();
        t_reset_mid();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule